// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Bank

This block collects up to 32 hardware interrupt sources behind a small register bus. Software selects a register with a word index, writes through a write strobe and reads through a read strobe. Hardware event pulses latch into a cause register. A mask register hides sources. A single interrupt line is raised while any cause that is not masked is pending.

Each source n uses bit n of every register. Software picks, per bit, how a latched cause is acknowledged: by writing a one to it, or by reading it. The masked view of the causes follows the same per-bit acknowledge rule. The mask is written directly or through separate write-one set and write-one clear aliases, so that one source can be masked without a read-modify-write.

Top module: `irq_cause_bank`

## Requirements
- R1: After reset the cause register is all zeros, the mask register is all ones, the mode register is all zeros (every bit write-one-to-clear), `irq_out` is 0 and `bus_rdata` is 0.
- R2: The word index selects the register: 0 mode, 1 cause, 2 masked view, 3 cause set, 4 mask, 5 mask set, 6 mask clear. Byte offset is 4 times the index. Index 7 reads zero. Read data is returned on `bus_rdata` in the cycle after `bus_rd` is sampled, and is zero in cycles with no read one cycle earlier.
- R3: A high `hw_event` bit sets its cause bit at the sampling edge. An event in the same cycle as a write-one or read acknowledge of that bit wins, and the bit stays set.
- R4: Writing a one to a bit at index 3 sets that cause bit. Reads of indices 3, 5 and 6 return zero.
- R5: A write to index 1 clears each cause bit whose write data bit is 1 and whose mode bit is 0. Cause bits with mode bit 1 ignore the write.
- R6: A read of index 1 returns the cause register and clears every cause bit whose mode bit is 1. Bits with mode bit 0 are unchanged.
- R7: Index 2 reads cause AND NOT mask. A read there clears only the bits it returned whose mode bit is 1. A write there clears only bits that have mode 0, mask 0 and write data 1.
- R8: Index 4 reads and writes the mask directly. Writing ones to index 5 sets those mask bits and writing ones to index 6 clears them. Other mask bits keep their value.
- R9: `irq_out` is the registered OR of cause AND NOT mask. It reflects the state one clock edge after that state was reached. A mask bit of 1 keeps its source off the output.
- R10: The mode register at index 0 reads back the last value written. A mode bit of 0 selects write-one-to-clear and a 1 selects clear-on-read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_event | input | N_SRC | Event pulses, one per source |
| bus_addr | input | 3 | Register word index |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | N_SRC | Write data |
| bus_rdata | output | N_SRC | Read data, valid the cycle after a read |
| irq_out | output | 1 | Interrupt request |

## Verification
All register changes from a write, an acknowledging read or an event happen at the edge that samples the stimulus. Read data is due one edge later, and `irq_out` is due one edge after the cause or mask has changed. The bench drives each stimulus for exactly one cycle on the falling edge. It reads `bus_rdata` at the next falling edge. Before it compares `irq_out`, it idles one extra cycle. A bench model updated in the same order predicts every value. This covers same-cycle event and acknowledge pairs, a walking-bit sweep of the interrupt line over all 32 sources, and a long pseudo-random run of mixed operations.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_MODE  = 3'd0,
        SEL_CAUSE = 3'd1,
        SEL_VIEW  = 3'd2,
        SEL_CSET  = 3'd3,
        SEL_MASK  = 3'd4,
        SEL_MSET  = 3'd5,
        SEL_MCLR  = 3'd6,
        SEL_NONE  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic wr_mode;
        logic wr_cause;
        logic wr_view;
        logic wr_cset;
        logic wr_mask;
        logic wr_mset;
        logic wr_mclr;
        logic rd_cause;
        logic rd_view;
    } strobe_t;

    function automatic logic is_write_only(reg_sel_e s);
        return (s == SEL_CSET) || (s == SEL_MSET) || (s == SEL_MCLR);
    endfunction

endpackage

// File: rtl/irq_bank_decode.sv
module irq_bank_decode
    import irq_bank_pkg::*;
(
    input  logic [SEL_W-1:0] addr,
    input  logic             wr,
    input  logic             rd,
    output reg_sel_e         sel,
    output strobe_t          strb
);
    always_comb begin
        sel           = reg_sel_e'(addr);
        strb          = '0;
        strb.wr_mode  = wr && (sel == SEL_MODE);
        strb.wr_cause = wr && (sel == SEL_CAUSE);
        strb.wr_view  = wr && (sel == SEL_VIEW);
        strb.wr_cset  = wr && (sel == SEL_CSET);
        strb.wr_mask  = wr && (sel == SEL_MASK);
        strb.wr_mset  = wr && (sel == SEL_MSET);
        strb.wr_mclr  = wr && (sel == SEL_MCLR);
        strb.rd_cause = rd && (sel == SEL_CAUSE);
        strb.rd_view  = rd && (sel == SEL_VIEW);
    end
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
    import irq_bank_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  strobe_t          strb,
    input  logic [N_SRC-1:0] wdata,
    output logic [N_SRC-1:0] mode_q,
    output logic [N_SRC-1:0] mask_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            mask_q <= '1;
        end else begin
            if (strb.wr_mode) mode_q <= wdata;
            if (strb.wr_mask)      mask_q <= wdata;
            else if (strb.wr_mset) mask_q <= mask_q | wdata;
            else if (strb.wr_mclr) mask_q <= mask_q & ~wdata;
        end
    end

    // R10
    mode_wr_chk: assert property (@(posedge clk) disable iff (rst)
        strb.wr_mode |=> (mode_q == $past(wdata)));

    // R8
    mset_chk: assert property (@(posedge clk) disable iff (rst)
        strb.wr_mset |=> ((mask_q & $past(wdata)) == $past(wdata)));

    // R8
    mclr_chk: assert property (@(posedge clk) disable iff (rst)
        strb.wr_mclr |=> ((mask_q & $past(wdata)) == '0));
endmodule

// File: rtl/irq_bank_cause.sv
module irq_bank_cause
    import irq_bank_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  strobe_t          strb,
    input  logic [N_SRC-1:0] wdata,
    input  logic [N_SRC-1:0] hw_event,
    input  logic [N_SRC-1:0] mode,
    input  logic [N_SRC-1:0] mask,
    output logic [N_SRC-1:0] cause_q
);
    logic [N_SRC-1:0] set_vec;
    logic [N_SRC-1:0] clr_vec;

    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
        logic w1c_hit;
        logic cor_hit;

        always_comb begin
            w1c_hit = wdata[i] && !mode[i] &&
                      (strb.wr_cause || (strb.wr_view && !mask[i]));
            cor_hit = mode[i] &&
                      (strb.rd_cause || (strb.rd_view && !mask[i]));
            clr_vec[i] = w1c_hit || cor_hit;
            set_vec[i] = hw_event[i] || (strb.wr_cset && wdata[i]);
        end

        always_ff @(posedge clk) begin
            if (rst)             cause_q[i] <= 1'b0;
            else if (set_vec[i]) cause_q[i] <= 1'b1;
            else if (clr_vec[i]) cause_q[i] <= 1'b0;
        end
    end

    // R3
    evt_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (hw_event != '0) |=> ((cause_q & $past(hw_event)) == $past(hw_event)));

    // R4
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((cause_q & ~$past(cause_q) & ~$past(hw_event)
                   & ~($past(strb.wr_cset) ? $past(wdata) : '0)) == '0));

    // R5
    cor_bits_ignore_write_chk: assert property (@(posedge clk) disable iff (rst)
        strb.wr_cause |=> ((($past(cause_q) & $past(mode)) & ~cause_q) == '0));
endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank
    import irq_bank_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] hw_event,
    input  logic [SEL_W-1:0] bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [N_SRC-1:0] bus_wdata,
    output logic [N_SRC-1:0] bus_rdata,
    output logic             irq_out
);
    reg_sel_e         sel;
    strobe_t          strb;
    logic [N_SRC-1:0] mode_q;
    logic [N_SRC-1:0] mask_q;
    logic [N_SRC-1:0] cause_q;
    logic [N_SRC-1:0] rd_mux;

    irq_bank_decode u_decode (
        .addr (bus_addr),
        .wr   (bus_wr),
        .rd   (bus_rd),
        .sel  (sel),
        .strb (strb)
    );

    irq_bank_ctrl #(.N_SRC(N_SRC)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .strb   (strb),
        .wdata  (bus_wdata),
        .mode_q (mode_q),
        .mask_q (mask_q)
    );

    irq_bank_cause #(.N_SRC(N_SRC)) u_cause (
        .clk      (clk),
        .rst      (rst),
        .strb     (strb),
        .wdata    (bus_wdata),
        .hw_event (hw_event),
        .mode     (mode_q),
        .mask     (mask_q),
        .cause_q  (cause_q)
    );

    always_comb begin
        case (sel)
            SEL_MODE:  rd_mux = mode_q;
            SEL_CAUSE: rd_mux = cause_q;
            SEL_VIEW:  rd_mux = cause_q & ~mask_q;
            SEL_MASK:  rd_mux = mask_q;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            irq_out   <= 1'b0;
        end else begin
            bus_rdata <= bus_rd ? rd_mux : '0;
            irq_out   <= |(cause_q & ~mask_q);
        end
    end

    // R4
    wo_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && is_write_only(sel)) |=> (bus_rdata == '0));

    // R9
    masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (&mask_q) |=> !irq_out);

    // R2
    idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> (bus_rdata == '0));
endmodule

// File: tb/irq_cause_bank_bench.sv
module irq_cause_bank_bench;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] hw_event = '0;
    logic [2:0]   bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic         irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [N-1:0] m_cause, m_mask, m_mode;
    logic [31:0]  lfsr = 32'h1ACE_B00C;

    always #10 clk = ~clk;

    irq_cause_bank #(.N_SRC(N)) u_irq_cause_bank (
        .clk(clk), .rst(rst), .hw_event(hw_event), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] exp_read(int idx);
        case (idx)
            0: return m_mode;
            1: return m_cause;
            2: return m_cause & ~m_mask;
            4: return m_mask;
            default: return '0;
        endcase
    endfunction

    function automatic string tag_of(int idx);
        case (idx)
            0: return "R10 mode readback";
            1: return "R6 cause read";
            2: return "R7 masked view read";
            4: return "R8 mask read";
            7: return "R2 unused index";
            default: return "R4 write-only read";
        endcase
    endfunction

    task automatic model_write(int idx, logic [N-1:0] d);
        case (idx)
            0: m_mode  = d;
            1: m_cause = m_cause & ~(d & ~m_mode);
            2: m_cause = m_cause & ~(d & ~m_mode & ~m_mask);
            3: m_cause = m_cause | d;
            4: m_mask  = d;
            5: m_mask  = m_mask | d;
            6: m_mask  = m_mask & ~d;
            default: ;
        endcase
    endtask

    task automatic model_read(int idx);
        if (idx == 1) m_cause = m_cause & ~m_mode;
        if (idx == 2) m_cause = m_cause & ~(m_mode & ~m_mask);
    endtask

    task automatic do_write(int idx, logic [N-1:0] d, logic [N-1:0] ev);
        @(negedge clk);
        bus_addr = 3'(idx); bus_wdata = d; bus_wr = 1'b1; hw_event = ev;
        @(negedge clk);
        bus_wr = 1'b0; hw_event = '0;
        model_write(idx, d);
        m_cause = m_cause | ev;
    endtask

    task automatic do_read(int idx, logic [N-1:0] ev, string tag);
        logic [N-1:0] e;
        e = exp_read(idx);
        @(negedge clk);
        bus_addr = 3'(idx); bus_rd = 1'b1; hw_event = ev;
        @(negedge clk);
        bus_rd = 1'b0; hw_event = '0;
        chk(tag, bus_rdata, e);
        model_read(idx);
        m_cause = m_cause | ev;
    endtask

    task automatic pulse(logic [N-1:0] ev);
        @(negedge clk);
        hw_event = ev;
        @(negedge clk);
        hw_event = '0;
        m_cause = m_cause | ev;
    endtask

    task automatic chk_irq(string tag);
        @(negedge clk);
        chk(tag, N'(irq_out), N'(|(m_cause & ~m_mask)));
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[30:0], 1'b0} ^ (lfsr[31] ? 32'h04C1_1DB7 : 32'h0);
    endtask

    initial begin
        m_cause = '0; m_mask = '1; m_mode = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 irq after reset", N'(irq_out), '0);
        chk("R1 rdata after reset", bus_rdata, '0);
        do_read(0, '0, "R1 mode reset");
        do_read(4, '0, "R1 mask reset");
        do_read(1, '0, "R1 cause reset");

        // R2 unused index and idle rdata
        do_read(7, '0, "R2 index 7 reads zero");
        @(negedge clk);
        chk("R2 rdata zero without read", bus_rdata, '0);

        // R4 cause set and write-only reads
        do_write(3, 32'h0000_00F0, '0);
        do_read(1, '0, "R4 cause set");
        do_write(4, 32'hDEAD_BEEF, '0);
        do_read(3, '0, "R4 cause-set reads zero");
        do_read(5, '0, "R4 mask-set reads zero");
        do_read(6, '0, "R4 mask-clear reads zero");

        // R10 mode write and readback
        do_write(0, 32'h0000_FF00, '0);
        do_read(0, '0, "R10 mode readback");

        // R5 write-one-to-clear only on mode-0 bits
        do_write(3, 32'h0000_FFFF, '0);
        do_write(1, 32'hFFFF_FFFF, '0);
        do_read(4, '0, "R5 mask untouched");
        do_write(0, '0, '0);
        do_read(1, '0, "R5 cor bits kept by write");

        // R6 clear-on-read
        do_write(0, 32'h0000_0F00, '0);
        do_read(1, '0, "R6 read returns cause");
        do_read(1, '0, "R6 cor bits cleared after read");

        // R3 event wins over same-cycle write-one clear
        do_write(0, '0, '0);
        do_write(1, 32'hFFFF_FFFF, '0);
        do_write(1, 32'h0000_0003, 32'h0000_0001);
        do_read(1, '0, "R3 event beats write clear");
        // R3 event wins over same-cycle clear-on-read
        do_write(0, 32'h0000_0010, '0);
        pulse(32'h0000_0010);
        do_read(1, 32'h0000_0010, "R3 event during cor read");
        do_read(1, '0, "R3 bit still set after cor read");

        // R7 masked view read and write clear scopes
        do_write(0, 32'h0000_00F0, '0);
        do_write(3, 32'h0000_FFFF, '0);
        do_write(4, 32'h0000_0F0F, '0);
        do_read(2, '0, "R7 masked view value");
        do_read(1, '0, "R7 view read clears visible cor only");
        do_write(2, 32'hFFFF_FFFF, '0);
        do_read(1, '0, "R7 view write clears visible w1c only");

        // R8 mask set and clear aliases
        do_write(4, 32'h00FF_00FF, '0);
        do_write(5, 32'h0F00_0F00, '0);
        do_read(4, '0, "R8 mask set alias");
        do_write(6, 32'h0000_00F0, '0);
        do_read(4, '0, "R8 mask clear alias");

        // R9 walking-bit sweep of the interrupt line
        do_write(0, '0, '0);
        do_write(4, '1, '0);
        do_write(1, '1, '0);
        for (int i = 0; i < N; i++) begin
            pulse(N'(1) << i);
            chk_irq("R9 masked source quiet");
            do_write(6, N'(1) << i, '0);
            chk_irq("R9 unmasked source raises irq");
            do_write(1, N'(1) << i, '0);
            chk_irq("R9 irq drops after clear");
            do_write(5, N'(1) << i, '0);
        end

        // mixed pseudo-random operations against the model
        for (int k = 0; k < 600; k++) begin
            int op;
            int ridx;
            step_lfsr();
            op = int'(lfsr[2:0]);
            ridx = int'(lfsr[6:4]);
            step_lfsr();
            if (op == 7) pulse(lfsr & 32'h8421_8421);
            else do_write(op, lfsr, '0);
            do_read(ridx, '0, tag_of(ridx));
            if (k % 8 == 0) chk_irq("R9 irq in mixed run");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule